// File: doc/BRIEF.md
# Add-with-carry instruction executor

This block is the execution slice of an 8-bit accumulator processor that carries out the add-with-carry instruction group. When an opcode byte arrives with its valid strobe while the unit is idle, the unit decodes it, obtains the operand, and writes back the accumulator and the flag register. The operand can come from three places:

- a general register in the register file;
- an immediate byte read from memory at the program counter;
- a memory byte at the address formed by the H and L registers.

The sum is accumulator plus operand plus the stored carry flag, wrapped to eight bits.

The register file is the accumulator, B, C, D, E, H and L, plus the flag register. It sits inside the block. The rest of the processor loads it through a write port, and it also loads the program counter. Memory is a synchronous byte port: read data appears one clock after the read strobe and address. The unit waits in its own state for that data and refuses new opcodes meanwhile. A one-cycle done pulse marks each completed instruction. Any opcode outside the group gives a one-cycle illegal pulse instead.

Top module: `adcx_top`

## Requirements
- R1: After an instruction of the group, the accumulator holds (A + operand + C) modulo 256, where C is flag bit 4 before the instruction.
- R2: Flag bit 4 (carry) is set exactly when A + operand + C exceeds 0xFF.
- R3: Flag bit 5 (half-carry) is set exactly when the low nibbles of A and the operand, plus C, exceed 0x0F.
- R4: Flag bit 7 (zero) is set exactly when the new accumulator is 0x00. Flag bit 6 (subtract) is cleared by every instruction of the group. Flag bits 3..0 always read zero.
- R5: The register forms are 0x88 through 0x8D and 0x8F. For them the operand is the register with index opcode[2:0]: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A. done rises one clock after the accepting edge, and no memory read is issued.
- R6: For opcode 0xCE, mem_rd is asserted with mem_addr equal to the program counter in the accepting cycle. The returned byte is the operand. done rises two clocks after the accepting edge, and the program counter then reads one higher, wrapping from 0xFFFF to 0x0000.
- R7: For opcode 0x8E, mem_rd is asserted with mem_addr = {H, L} in the accepting cycle. The returned byte is the operand, done rises two clocks after the accepting edge, and the program counter is unchanged.
- R8: Any other opcode sets illegal for exactly one cycle, one clock after the accepting edge. done stays low, and the accumulator, the flags and the program counter are unchanged.
- R9: While waiting for memory data, op_ready is low and a valid opcode is ignored.
- R10: Synchronous active-low reset clears all registers, the flags and the program counter. It also clears done and illegal, and leaves the unit ready.
- R11: The write port loads the register indexed by wr_idx (opcode encoding, index 6 = flags, with bits 3..0 forced to zero). pc_load loads the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode present |
| op_code | input | 8 | Opcode byte |
| op_ready | output | 1 | Unit can accept an opcode |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one clock after mem_rd |
| done | output | 1 | Instruction completed (one cycle) |
| illegal | output | 1 | Opcode outside the group (one cycle) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Register index (6 = flags) |
| wr_data | input | 8 | Register write data |
| pc_load | input | 1 | Program counter load |
| pc_wdata | input | 16 | Program counter load value |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 8 | Flag register |
| pc_out | output | 16 | Program counter |

## Verification
The arithmetic is swept over every accumulator value against sixteen spread operand values, with the carry both clear and set. These sweeps separate a missing carry-in, a wrong carry-out bit and a half-carry taken from the wrong nibble. The edge sums 0xFF+0x00+1, 0x0F+0x00+1 and A+A+1 are run on their own. Every one of the 256 opcode values is then issued from a state where all registers differ. A wrong register index, a form confused with another, an illegal opcode treated as legal, or a wrong cycle count therefore shows up as a wrong accumulator or strobe. Immediate and H:L forms are run over many addresses, including the program counter wrap. A stray opcode is offered during the memory wait.

// File: rtl/adcx_pkg.sv
// Package: shared encodings for the add-with-carry executor.
// Assumes 8-bit opcodes; data width is a parameter of the modules.
package adcx_pkg;

    // Operand source picked by the decoder.
    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_IMM = 2'd1,
        SRC_HL  = 2'd2,
        SRC_BAD = 2'd3
    } src_e;

    // Control states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    // Register file indexes (opcode low bits; 6 holds the flags).
    localparam int IDX_H = 4;
    localparam int IDX_L = 5;
    localparam int IDX_F = 6;
    localparam int IDX_A = 7;

    // Flag bit positions.
    localparam int FLAG_Z = 7;
    localparam int FLAG_N = 6;
    localparam int FLAG_H = 5;
    localparam int FLAG_C = 4;

    localparam logic [7:0] OP_IMM = 8'hCE;

    // Classify an opcode byte into its operand source.
    function automatic src_e decode_src(input logic [7:0] op);
        if (op[7:3] == 5'b10001) begin
            if (op[2:0] == 3'b110) return SRC_HL;
            return SRC_REG;
        end
        if (op == OP_IMM) return SRC_IMM;
        return SRC_BAD;
    endfunction

endpackage

// File: rtl/adcx_alu.sv
// Module: adcx_alu
// Adds two operands and a carry-in. Produces the wrapped sum and the
// flag byte: zero, subtract (always clear), half-carry out of the low
// half, carry out of the top bit. Low flag bits are zero.
// Assumes DATA_W >= 8 and even; flag positions come from the package.
module adcx_alu
    import adcx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] flags
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [HALF:0]   low;

    // Full-width and low-half additions, each including the carry-in.
    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
    end

    // Result and flag byte assembly.
    always_comb begin
        sum            = full[DATA_W-1:0];
        flags          = '0;
        flags[FLAG_Z]  = (full[DATA_W-1:0] == '0);
        flags[FLAG_N]  = 1'b0;
        flags[FLAG_H]  = low[HALF];
        flags[FLAG_C]  = full[DATA_W];
    end

endmodule

// File: rtl/adcx_regfile.sv
// Module: adcx_regfile
// Holds eight DATA_W-bit entries indexed like the opcode low bits:
// 0..5 = B,C,D,E,H,L, 6 = flags, 7 = accumulator. Executor writes to
// A and flags take priority over the external write port. Flag low
// bits are forced to zero on every write.
module adcx_regfile
    import adcx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic [2:0]        ext_idx,
    input  logic [DATA_W-1:0] ext_wdata,
    input  logic              exe_we,
    input  logic [DATA_W-1:0] exe_acc,
    input  logic [DATA_W-1:0] exe_flags,
    input  logic [2:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] h_val,
    output logic [DATA_W-1:0] l_val
);
    localparam logic [DATA_W-1:0] FLAG_MASK = {{(DATA_W-4){1'b1}}, 4'b0000};

    logic [N_REGS*DATA_W-1:0] flat;

    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
        localparam bit IS_A = (gi == IDX_A);
        localparam bit IS_F = (gi == IDX_F);
        logic [DATA_W-1:0] q;

        // One storage entry: executor result first, then external write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (exe_we && IS_A) begin
                q <= exe_acc;
            end else if (exe_we && IS_F) begin
                q <= exe_flags & FLAG_MASK;
            end else if (ext_we && (ext_idx == 3'(gi))) begin
                q <= IS_F ? (ext_wdata & FLAG_MASK) : ext_wdata;
            end
        end

        assign flat[gi*DATA_W +: DATA_W] = q;
    end

    assign rd_data = flat[rd_idx*DATA_W +: DATA_W];
    assign acc     = flat[IDX_A*DATA_W +: DATA_W];
    assign flags   = flat[IDX_F*DATA_W +: DATA_W];
    assign h_val   = flat[IDX_H*DATA_W +: DATA_W];
    assign l_val   = flat[IDX_L*DATA_W +: DATA_W];

endmodule

// File: rtl/adcx_ctrl.sv
// Module: adcx_ctrl
// Accepts an opcode when idle and decodes its operand source.
// Register forms finish at the accepting edge. Memory forms issue a
// read in the accepting cycle and finish on the next edge, when the
// data has returned. Owns the program counter.
// Assumes memory read latency of exactly one clock.
module adcx_ctrl
    import adcx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] h_val,
    input  logic [DATA_W-1:0] l_val,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_wdata,
    output logic              op_ready,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              exe_we,
    output logic              use_mem,
    output logic [2:0]        rd_idx,
    output logic              done,
    output logic              illegal,
    output logic [ADDR_W-1:0] pc
);
    st_e  state;
    src_e src;
    src_e pend;
    logic accept;

    assign src      = decode_src(op_code);
    assign accept   = op_valid && (state == ST_IDLE);
    assign op_ready = (state == ST_IDLE);
    assign mem_rd   = accept && ((src == SRC_IMM) || (src == SRC_HL));
    assign mem_addr = (src == SRC_IMM) ? pc : {h_val, l_val};
    assign exe_we   = (accept && (src == SRC_REG)) || (state == ST_WAIT);
    assign use_mem  = (state == ST_WAIT);
    assign rd_idx   = op_code[2:0];

    // State sequencing: memory forms spend one cycle waiting for data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (state == ST_WAIT) begin
            state <= ST_IDLE;
        end else if (mem_rd) begin
            state <= ST_WAIT;
        end
    end

    // Remember the source of an outstanding memory form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= SRC_REG;
        end else if (accept) begin
            pend <= src;
        end
    end

    // Completion and illegal-opcode strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= exe_we;
            illegal <= accept && (src == SRC_BAD);
        end
    end

    // Program counter: step past the immediate byte, else external load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if ((state == ST_WAIT) && (pend == SRC_IMM)) begin
            pc <= pc + ADDR_W'(1);
        end else if (pc_load) begin
            pc <= pc_wdata;
        end
    end

    // R9: the wait state lasts exactly one cycle
    p_wait_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (state == ST_IDLE));

    // R5: a register form completes one clock after acceptance
    p_reg_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (src == SRC_REG)) |=> done);

    // R8: illegal and done never coincide
    p_illegal_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !done);

endmodule

// File: rtl/adcx_top.sv
// Module: adcx_top
// Add-with-carry executor: controller, register file and adder.
// The operand comes from the register file or, in the wait state,
// from the memory read data. The carry-in is the stored carry flag.
// Assumes the address is formed from two data-width registers.
module adcx_top
    import adcx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [7:0]            op_code,
    output logic                  op_ready,
    output logic                  mem_rd,
    output logic [2*DATA_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  done,
    output logic                  illegal,
    input  logic                  wr_en,
    input  logic [2:0]            wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  pc_load,
    input  logic [2*DATA_W-1:0]   pc_wdata,
    output logic [DATA_W-1:0]     acc_out,
    output logic [DATA_W-1:0]     flags_out,
    output logic [2*DATA_W-1:0]   pc_out
);
    localparam int ADDR_W = 2 * DATA_W;

    logic              exe_we;
    logic              use_mem;
    logic [2:0]        rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] h_val;
    logic [DATA_W-1:0] l_val;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] new_flags;

    adcx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .h_val    (h_val),
        .l_val    (l_val),
        .pc_load  (pc_load),
        .pc_wdata (pc_wdata),
        .op_ready (op_ready),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .exe_we   (exe_we),
        .use_mem  (use_mem),
        .rd_idx   (rd_idx),
        .done     (done),
        .illegal  (illegal),
        .pc       (pc_out)
    );

    adcx_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_we    (wr_en),
        .ext_idx   (wr_idx),
        .ext_wdata (wr_data),
        .exe_we    (exe_we),
        .exe_acc   (sum),
        .exe_flags (new_flags),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .acc       (acc_out),
        .flags     (flags_out),
        .h_val     (h_val),
        .l_val     (l_val)
    );

    // Operand select: memory data during the wait state.
    assign operand = use_mem ? mem_rdata : rd_data;

    adcx_alu #(.DATA_W(DATA_W)) u_alu (
        .a     (acc_out),
        .b     (operand),
        .cin   (flags_out[FLAG_C]),
        .sum   (sum),
        .flags (new_flags)
    );

    // R4: zero flag agrees with the accumulator after completion
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLAG_Z] == (acc_out == '0)));

    // R4: subtract and low flag bits are clear after completion
    p_sub_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flags_out[FLAG_N] && (flags_out[3:0] == 4'h0)));

    // R8: an illegal opcode leaves accumulator and flags untouched
    p_hold_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !$past(wr_en)) |-> ($stable(acc_out) && $stable(flags_out)));

endmodule

// File: tb/test_adcx_top.sv
module test_adcx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        op_ready;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        done;
    logic        illegal;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = 3'd0;
    logic [7:0]  wr_data = 8'h00;
    logic        pc_load = 1'b0;
    logic [15:0] pc_wdata = 16'h0000;
    logic [7:0]  acc_out;
    logic [7:0]  flags_out;
    logic [15:0] pc_out;

    int total = 0;
    int bad = 0;
    logic [7:0]  sh [8];
    logic [15:0] pc_sh;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcx_top i_adcx_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_ready(op_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_load(pc_load), .pc_wdata(pc_wdata), .acc_out(acc_out),
        .flags_out(flags_out), .pc_out(pc_out)
    );

    // Memory contents are a fixed function of the address.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] + (a[15:8] * 8'd3)) ^ 8'hA5;
    endfunction

    // One-clock read latency memory model.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_byte(mem_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setreg(input int idx, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        sh[idx] = (idx == 6) ? (v & 8'hF0) : v;
    endtask

    task automatic setpc(input logic [15:0] v);
        @(negedge clk);
        pc_load = 1'b1; pc_wdata = v;
        @(negedge clk);
        pc_load = 1'b0;
        pc_sh = v;
    endtask

    // Issue one opcode and compare against an arithmetic model.
    task automatic do_op(input logic [7:0] op);
        int kind;
        logic [7:0]  opnd;
        logic [15:0] addr;
        logic [8:0]  full;
        logic [4:0]  low;
        logic [7:0]  ea;
        logic [7:0]  ef;
        logic        cin;
        if (op[7:3] == 5'b10001 && op[2:0] != 3'b110) kind = 0;
        else if (op == 8'hCE) kind = 1;
        else if (op == 8'h8E) kind = 2;
        else kind = 3;
        addr = (kind == 1) ? pc_sh : {sh[4], sh[5]};
        opnd = (kind == 0) ? sh[op[2:0]] : mem_byte(addr);
        cin  = sh[6][4];
        full = {1'b0, sh[7]} + {1'b0, opnd} + {8'h00, cin};
        low  = {1'b0, sh[7][3:0]} + {1'b0, opnd[3:0]} + {4'h0, cin};
        ea   = full[7:0];
        ef   = {(ea == 8'h00), 1'b0, low[4], full[8], 4'h0};

        @(negedge clk);
        op_valid = 1'b1; op_code = op;
        #1;
        if (kind == 1) begin
            chk("R6 mem_rd", {31'd0, mem_rd}, 32'd1);
            chk("R6 mem_addr", {16'd0, mem_addr}, {16'd0, pc_sh});
        end else if (kind == 2) begin
            chk("R7 mem_rd", {31'd0, mem_rd}, 32'd1);
            chk("R7 mem_addr", {16'd0, mem_addr}, {16'd0, addr});
        end else begin
            chk("R5 no mem_rd", {31'd0, mem_rd}, 32'd0);
        end
        @(negedge clk);
        if (kind == 1 || kind == 2) begin
            chk("R9 op_ready low in wait", {31'd0, op_ready}, 32'd0);
            chk("R6 R7 done not early", {31'd0, done}, 32'd0);
            op_code = 8'h00;
            @(negedge clk);
            op_valid = 1'b0;
            chk("R9 opcode ignored in wait", {31'd0, illegal}, 32'd0);
        end else begin
            op_valid = 1'b0;
        end
        if (kind == 3) begin
            chk("R8 illegal strobe", {31'd0, illegal}, 32'd1);
            chk("R8 no done", {31'd0, done}, 32'd0);
            chk("R8 acc held", {24'd0, acc_out}, {24'd0, sh[7]});
            chk("R8 flags held", {24'd0, flags_out}, {24'd0, sh[6]});
            chk("R8 pc held", {16'd0, pc_out}, {16'd0, pc_sh});
        end else begin
            if (kind == 1) pc_sh = pc_sh + 16'd1;
            chk("R5 R6 R7 done", {31'd0, done}, 32'd1);
            chk("R1 acc", {24'd0, acc_out}, {24'd0, ea});
            chk("R2 R3 R4 flags", {24'd0, flags_out}, {24'd0, ef});
            chk("R6 R7 pc", {16'd0, pc_out}, {16'd0, pc_sh});
            sh[7] = ea;
            sh[6] = ef;
        end
        @(negedge clk);
        chk("R8 strobes one cycle", {30'd0, done, illegal}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) sh[i] = 8'h00;
        pc_sh = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R10 acc reset", {24'd0, acc_out}, 32'd0);
        chk("R10 flags reset", {24'd0, flags_out}, 32'd0);
        chk("R10 pc reset", {16'd0, pc_out}, 32'd0);
        chk("R10 strobes reset", {30'd0, done, illegal}, 32'd0);
        chk("R10 ready in reset", {31'd0, op_ready}, 32'd1);
        rst_n = 1'b1;

        // R11: flag low bits forced to zero on write
        setreg(6, 8'hFF);
        chk("R11 flag write masked", {24'd0, flags_out}, 32'h000000F0);

        // R4 corner cases: 0xFF+0x00+1, 0x0F+0x00+1, A+A+1
        setreg(0, 8'h00); setreg(7, 8'hFF); setreg(6, 8'h10);
        do_op(8'h88);
        chk("R4 corner FF wrap flags", {24'd0, flags_out}, 32'h000000B0);
        setreg(7, 8'h0F); setreg(6, 8'h10);
        do_op(8'h88);
        chk("R3 corner 0F half-carry", {24'd0, flags_out}, 32'h00000020);
        setreg(7, 8'h88); setreg(6, 8'h10);
        do_op(8'h8F);
        chk("R1 corner A+A+1", {24'd0, acc_out}, 32'h00000011);

        // R1 R2 R3: accumulator sweep against spread operands, both carries
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 17) begin
                for (int c = 0; c < 2; c++) begin
                    setreg(7, 8'(a));
                    setreg(6, c ? 8'h10 : 8'h00);
                    setreg(0, 8'(b));
                    do_op(8'h88);
                end
            end
        end

        // R5: each register index, with distinct register contents
        for (int k = 0; k < 32; k++) begin
            for (int r = 0; r < 8; r++) begin
                if (r != 6) setreg(r, 8'(k * 37 + r * 29 + 3));
            end
            setreg(6, (k % 2) ? 8'hF0 : 8'h40);
            for (int r = 0; r < 8; r++) begin
                if (r != 6) do_op(8'h88 + 8'(r));
            end
        end

        // R8 and decode: every opcode value from a known state
        for (int op = 0; op < 256; op++) begin
            for (int r = 0; r < 8; r++) begin
                if (r != 6) setreg(r, 8'(op + r * 41 + 7));
            end
            setreg(6, 8'(op));
            setpc(16'(op * 257));
            do_op(8'(op));
        end

        // R6: immediate form over many addresses, including the wrap
        setpc(16'hFFFF);
        setreg(7, 8'h5C); setreg(6, 8'h10);
        do_op(8'hCE);
        chk("R6 pc wrap", {16'd0, pc_out}, 32'd0);
        for (int k = 0; k < 64; k++) begin
            setpc(16'(k * 1031));
            setreg(7, 8'(k * 13));
            setreg(6, 8'(k * 16));
            do_op(8'hCE);
            do_op(8'hCE);
        end

        // R7: H:L form over many addresses
        for (int k = 0; k < 64; k++) begin
            setreg(4, 8'(k * 7 + 1));
            setreg(5, 8'(255 - k * 3));
            setreg(7, 8'(k * 5));
            setreg(6, 8'(k * 48));
            do_op(8'h8E);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule